// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a byte-oriented I2C master that software runs through a small byte-wide register port. Register side effects start every bus action. Setting the master bit in the control register issues a START, and clearing it issues a STOP. Setting the restart bit while the bus is owned issues a repeated START. Writing the data register in transmit mode sends a byte. Reading the data register in receive mode returns the last byte and begins the next one. Each finished byte sets a completion flag, and that flag can drive an interrupt line.

The bus engine is a state machine with six states:
- IDLE: both lines released.
- START: SDA falls while SCL is high, then SCL falls.
- HOLD: SCL is held low between bytes.
- XFER: nine bit slots, eight data bits and one acknowledge.
- RSTART: SDA high, SCL high, SDA falls, SCL falls.
- STOP: SDA low, SCL high, SDA rises.

The transitions are:
- IDLE→START on a master request.
- START→HOLD and RSTART→HOLD when their sequence ends.
- HOLD→STOP, HOLD→RSTART and HOLD→XFER on a pending stop, restart or byte request, checked in that priority order.
- XFER→HOLD after the acknowledge slot.
- STOP→IDLE when SDA has risen.
- Any state→IDLE when the module enable is cleared.

Every bit slot is four quarter periods long. A 6-bit divider code sets the length of a quarter.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the control register reads 0x00 and the status register reads 0x80. SCL and SDA are released (1) and irq is 0.
- R2: The registers sit at fixed offsets: own address 0x00 (8 bits, read/write, no effect on the bus), divider 0x04 (6 bits, bits 7:6 read 0), control 0x08, status 0x0C, data 0x10. Control bits: 7 enable, 6 interrupt enable, 5 master, 4 transmit, 3 send-NACK, 2 restart (self-clearing, reads 0). Status bits: 7 no byte in flight, 6 addressed as slave (always 0), 5 bus busy, 4 arbitration lost, 1 byte complete, 0 received NACK.
- R3: A control write that changes bit 5 from 0 to 1, with bit 7 set, drives SDA low while SCL is high, then SCL low, and sets status bit 5.
- R4: In transmit mode (control bit 4 = 1), a data write sends 8 bits MSB first and then releases SDA for a ninth clock. The level sampled in that ninth clock goes to status bit 0. Status bit 1 is then set and status bit 7 reads 1 again. Within a byte, SDA changes only while SCL is low.
- R5: Between bytes, SCL stays low and no SCL rising edge occurs until software writes or reads the data register.
- R6: In receive mode (control bit 4 = 0), a data read starts a byte. SDA is released for 8 bits, sampled MSB first, and the next data read returns them. In the ninth clock the master drives control bit 3 (0 gives ACK low, 1 gives NACK high). That bit is captured when the byte starts, so a change during a byte affects only later bytes.
- R7: A control write that changes bit 5 from 1 to 0 drives a STOP (SDA rises while SCL is high) once any byte in flight has finished. Status bit 5 clears after the STOP, and both lines end released.
- R8: A data read made after the master bit has been cleared returns the final received byte and causes no SCL rising edge.
- R9: A control write with bit 2 = 1 while bit 5 stays 1 drives a repeated START: a START condition with no STOP before it. Status bit 5 stays 1.
- R10: Writing 0 to status bit 1 clears it. irq equals status bit 1 AND control bit 6.
- R11: A quarter period lasts ratio/4 module clocks, where ratio = max(22, (16 + 2*code[2:0]) << code[5:3]). SCL stays high for two quarters in each bit.
- R12: Writing 0x00 to control returns the bus engine to IDLE by the next cycle, releases both lines and clears status bit 5, even in the middle of a byte.
- R13: In transmit mode, if the master releases SDA in a data bit and the line reads low, status bit 4 is set. Writing 0 to status bit 4 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access (data reads have side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Byte-complete interrupt request |
| scl_out | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_out | output | 1 | SDA drive, 0 pulls low, 1 releases |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The assertions check a fixed set of properties on every cycle:
- SDA holds steady while SCL is high inside a byte.
- Bus busy rises only when leaving IDLE and falls only on entering IDLE.
- A cleared enable forces IDLE.
- Quarter ticks never come back to back.
- The completion flag rises only after a finished acknowledge slot.

Only the bench's scenarios can show:
- The byte values sent and received.
- The ACK/NACK the master drives and its capture at byte start.
- The START, STOP and repeated-START conditions seen on the lines.
- The SCL high time for a given divider code.
- The absence of extra SCL clocks after the master bit is cleared.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 6;
    localparam int CNT_W  = 12;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_OWN  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h10;

    localparam int CB_EN   = 7;
    localparam int CB_IE   = 6;
    localparam int CB_MST  = 5;
    localparam int CB_TX   = 4;
    localparam int CB_NACK = 3;
    localparam int CB_RS   = 2;

    localparam int SB_ARB  = 4;
    localparam int SB_DONE = 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_HOLD, ST_XFER, ST_RSTART, ST_STOP
    } bus_st_e;

    // SCL period in module clocks for a divider code
    function automatic logic [CNT_W-1:0] scl_ratio(input logic [DIV_W-1:0] c);
        logic [CNT_W-1:0] m;
        m = 12'd16 + {8'd0, c[2:0], 1'b0};
        m = m << c[5:3];
        if (m < 12'd22) m = 12'd22;
        return m;
    endfunction
endpackage

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick
    import i2cm_pkg::*;
#(
    parameter int CODE_W = DIV_W,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [CW-1:0] qlen;
    logic [CW-1:0] cnt;

    assign qlen = scl_ratio(code) >> 2;
    assign tick = run && (cnt >= qlen - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // R11
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/i2cm_bus_fsm.sv
module i2cm_bus_fsm
    import i2cm_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          rs_req,
    input  logic          go,
    input  logic          tx_mode,
    input  logic          nack_sel,
    input  logic [DW-1:0] tx_byte,
    input  logic          sda_in,
    output logic          run,
    output logic          scl_out,
    output logic          sda_out,
    output logic          busy,
    output logic          in_xfer,
    output logic          byte_done,
    output logic          arb_pulse,
    output logic          ack_q,
    output logic [DW-1:0] rx_byte
);
    localparam int BIT_W = $clog2(DW + 1);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DW);

    bus_st_e          st, nxt;
    logic [1:0]       ph;
    logic [BIT_W-1:0] bitn;
    logic [DW-1:0]    shreg;
    logic             samp, dir_tx, nack_lat;
    logic             stop_p, rs_p, go_p;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (start_req) nxt = ST_START;
            ST_START:  if (tick && ph == 2'd1) nxt = ST_HOLD;
            ST_HOLD:   if (stop_p) nxt = ST_STOP;
                       else if (rs_p) nxt = ST_RSTART;
                       else if (go_p) nxt = ST_XFER;
            ST_XFER:   if (tick && ph == 2'd3 && bitn == ACK_SLOT) nxt = ST_HOLD;
            ST_RSTART: if (tick && ph == 2'd3) nxt = ST_HOLD;
            ST_STOP:   if (tick && ph == 2'd2) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!enable) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE; ph <= '0; bitn <= '0; shreg <= '0; samp <= 1'b1;
            dir_tx <= 1'b0; nack_lat <= 1'b0; stop_p <= 1'b0; rs_p <= 1'b0;
            go_p <= 1'b0; busy <= 1'b0; ack_q <= 1'b0; rx_byte <= '0;
        end else begin
            st <= nxt;
            if (nxt != st)  ph <= '0;
            else if (tick)  ph <= ph + 1'b1;
            if (!enable) begin
                stop_p <= 1'b0; rs_p <= 1'b0; go_p <= 1'b0; busy <= 1'b0;
            end else begin
                if (stop_req) stop_p <= 1'b0 | 1'b1;
                else if (st == ST_HOLD || st == ST_IDLE) stop_p <= 1'b0;
                if (rs_req) rs_p <= 1'b1;
                else if ((st == ST_HOLD && !stop_p) || st == ST_IDLE) rs_p <= 1'b0;
                if (go) go_p <= 1'b1;
                else if ((st == ST_HOLD && !stop_p && !rs_p) || st == ST_IDLE) go_p <= 1'b0;
                if (st == ST_IDLE && nxt == ST_START) busy <= 1'b1;
                else if (st == ST_STOP && nxt == ST_IDLE) busy <= 1'b0;
            end
            if (st == ST_HOLD && nxt == ST_XFER) begin
                shreg <= tx_byte; dir_tx <= tx_mode; nack_lat <= nack_sel; bitn <= '0;
            end else if (st == ST_XFER && tick) begin
                if (ph == 2'd1) begin
                    samp <= sda_in;
                    if (bitn == ACK_SLOT && dir_tx) ack_q <= sda_in;
                end
                if (ph == 2'd3) begin
                    if (bitn != ACK_SLOT) shreg <= {shreg[DW-2:0], samp};
                    bitn <= bitn + 1'b1;
                end
            end
            if (byte_done) rx_byte <= shreg;
        end
    end

    always_comb begin
        scl_out = 1'b1;
        sda_out = 1'b1;
        unique case (st)
            ST_IDLE:   begin scl_out = 1'b1; sda_out = 1'b1; end
            ST_START:  begin scl_out = (ph == 2'd0); sda_out = 1'b0; end
            ST_HOLD:   begin scl_out = 1'b0; sda_out = 1'b1; end
            ST_XFER:   begin
                scl_out = (ph == 2'd1) || (ph == 2'd2);
                if (bitn != ACK_SLOT) sda_out = dir_tx ? shreg[DW-1] : 1'b1;
                else                  sda_out = dir_tx ? 1'b1 : nack_lat;
            end
            ST_RSTART: begin scl_out = (ph == 2'd1) || (ph == 2'd2); sda_out = (ph < 2'd2); end
            ST_STOP:   begin scl_out = (ph != 2'd0); sda_out = (ph == 2'd2); end
            default:   begin scl_out = 1'b1; sda_out = 1'b1; end
        endcase
        run       = (st == ST_START) || (st == ST_XFER) || (st == ST_RSTART) || (st == ST_STOP);
        in_xfer   = (st == ST_XFER);
        byte_done = (st == ST_XFER) && tick && (ph == 2'd3) && (bitn == ACK_SLOT);
        arb_pulse = (st == ST_XFER) && tick && (ph == 2'd1) && (bitn != ACK_SLOT)
                    && dir_tx && shreg[DW-1] && !sda_in;
    end

    // R4
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && $past(st) == ST_XFER && scl_out && $past(scl_out))
        |-> sda_out == $past(sda_out));
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(st) == ST_IDLE);
    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> st == ST_IDLE);
    // R12
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (st == ST_IDLE && !busy));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              scl_out,
    output logic              sda_out,
    input  logic              sda_in
);
    logic [DATA_W-1:0] own_q, ctrl_q, dat_q, rx_byte, stat;
    logic [DIV_W-1:0]  div_q;
    logic iif_q, arb_q;
    logic tick, run, busy, in_xfer, byte_done, arb_pulse, ack_q;
    logic wr_ctrl, wr_stat, wr_data, rd_data;
    logic start_req, stop_req, rs_req, go;

    assign wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
    assign wr_stat = reg_wr && reg_addr == OFS_STAT;
    assign wr_data = reg_wr && reg_addr == OFS_DATA;
    assign rd_data = reg_rd && reg_addr == OFS_DATA;

    assign start_req = wr_ctrl && reg_wdata[CB_EN] && reg_wdata[CB_MST] && !ctrl_q[CB_MST];
    assign stop_req  = wr_ctrl && ctrl_q[CB_MST] && !reg_wdata[CB_MST];
    assign rs_req    = wr_ctrl && ctrl_q[CB_MST] && reg_wdata[CB_MST] && reg_wdata[CB_RS];
    assign go        = ctrl_q[CB_MST] && ((wr_data && ctrl_q[CB_TX]) || (rd_data && !ctrl_q[CB_TX]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '0; ctrl_q <= '0; dat_q <= '0; div_q <= '0;
            iif_q <= 1'b0; arb_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_OWN) own_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_DIV) div_q <= reg_wdata[DIV_W-1:0];
            if (wr_ctrl) ctrl_q <= reg_wdata & ~(DATA_W'(1) << CB_RS);
            if (wr_data) dat_q <= reg_wdata;
            if (byte_done) iif_q <= 1'b1;
            else if (wr_stat && !reg_wdata[SB_DONE]) iif_q <= 1'b0;
            if (arb_pulse) arb_q <= 1'b1;
            else if (wr_stat && !reg_wdata[SB_ARB]) arb_q <= 1'b0;
        end
    end

    assign stat = {!in_xfer, 1'b0, busy, arb_q, 2'b00, iif_q, ack_q};
    assign irq  = iif_q && ctrl_q[CB_IE];

    always_comb begin
        unique case (reg_addr)
            OFS_OWN:  reg_rdata = own_q;
            OFS_DIV:  reg_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
            OFS_CTRL: reg_rdata = ctrl_q;
            OFS_STAT: reg_rdata = stat;
            OFS_DATA: reg_rdata = rx_byte;
            default:  reg_rdata = '0;
        endcase
    end

    i2cm_quarter_tick #(.CODE_W(DIV_W), .CW(CNT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .code(div_q), .tick(tick)
    );

    i2cm_bus_fsm #(.DW(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_q[CB_EN]), .tick(tick),
        .start_req(start_req), .stop_req(stop_req), .rs_req(rs_req), .go(go),
        .tx_mode(ctrl_q[CB_TX]), .nack_sel(ctrl_q[CB_NACK]), .tx_byte(dat_q),
        .sda_in(sda_in), .run(run), .scl_out(scl_out), .sda_out(sda_out),
        .busy(busy), .in_xfer(in_xfer), .byte_done(byte_done),
        .arb_pulse(arb_pulse), .ack_q(ack_q), .rx_byte(rx_byte)
    );

    // R10
    iif_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iif_q && !$past(iif_q)) |-> $past(byte_done));
endmodule

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, scl_out, sda_out, sda_line, slave_line;
    logic [8:0] pat = 9'h1FF;
    logic [8:0] cap = '0;
    int idx = 0, rises = 0, starts = 0, stops = 0;
    int cyc = 0, rise_t = 0, hi_len = 0;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign slave_line = (idx < 9) ? pat[8 - idx] : 1'b1;
    assign sda_line   = sda_out & slave_line;

    i2c_byte_master i_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_out(scl_out), .sda_out(sda_out), .sda_in(sda_line)
    );

    always @(posedge clk) cyc++;
    always @(posedge scl_out) begin rise_t = cyc; cap = {cap[7:0], sda_line}; rises++; end
    always @(negedge scl_out) begin hi_len = cyc - rise_t; idx++; end
    always @(negedge sda_out) if (scl_out === 1'b1) starts++;
    always @(posedge sda_out) if (scl_out === 1'b1) stops++;

    localparam logic [4:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTRL = 5'h08,
                           A_STAT = 5'h0C, A_DATA = 5'h10;
    // {tx byte, slave ack level, expected status bit 0}
    localparam logic [9:0] TX_VEC [5] = '{
        {8'hA5, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b1}, {8'hFF, 1'b0, 1'b0},
        {8'h00, 1'b1, 1'b1}, {8'h81, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, req, n, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int s0, p0, r0;
        idle(3); rst_n = 1'b1; idle(2);
        // R1 reset state
        rd(A_STAT, v); chk(v == 8'h80, "R1 status", v, 8'h80);
        rd(A_CTRL, v); chk(v == 8'h00, "R1 control", v, 0);
        chk(scl_out && sda_out, "R1 lines", {scl_out, sda_out}, 3);
        chk(!irq, "R1 irq", irq, 0);
        // R2 register map
        wr(A_OWN, 8'h5A); rd(A_OWN, v); chk(v == 8'h5A, "R2 own addr", v, 8'h5A);
        wr(A_DIV, 8'hC0); rd(A_DIV, v); chk(v == 8'h00, "R2 divider width", v, 0);
        chk(scl_out && sda_out, "R2 own addr no bus effect", {scl_out, sda_out}, 3);
        // R3 START
        wr(A_CTRL, 8'hC0);
        s0 = starts;
        wr(A_CTRL, 8'hF0); idle(20);
        chk(starts == s0 + 1, "R3 start seen", starts - s0, 1);
        rd(A_STAT, v); chk(v[5], "R3 busy", v, 8'hA0);
        chk(!scl_out, "R3 scl low after start", scl_out, 0);
        // R4 R10 R11 table of transmit bytes
        for (int k = 0; k < 5; k++) begin
            pat = {8'hFF, TX_VEC[k][1]}; idx = 0;
            wr(A_DATA, TX_VEC[k][9:2]);
            idle(2); rd(A_STAT, v); chk(!v[7], "R4 in flight", v[7], 0);
            wait_irq("R4 byte done");
            chk(cap[8:1] == TX_VEC[k][9:2], "R4 sent byte", cap[8:1], TX_VEC[k][9:2]);
            chk(cap[0] == TX_VEC[k][1], "R4 ack slot released", cap[0], TX_VEC[k][1]);
            rd(A_STAT, v);
            chk(v[0] == TX_VEC[k][0], "R4 rx nack bit", v[0], TX_VEC[k][0]);
            chk(v[1] && v[7], "R4 done flags", v, 8'h82);
            chk(hi_len == 10, "R11 high time code 0", hi_len, 10);
            r0 = rises; idle(40);
            chk(rises == r0 && !scl_out, "R5 scl held low", rises - r0, 0);
            wr(A_STAT, 8'h00);
            chk(!irq, "R10 irq cleared", irq, 0);
            rd(A_STAT, v); chk(!v[1], "R10 flag cleared", v[1], 0);
        end
        // R13 arbitration lost
        pat = 9'b0_1111_1111; idx = 0;
        wr(A_DATA, 8'h80); wait_irq("R13 byte done");
        rd(A_STAT, v); chk(v[4], "R13 arb lost set", v, 8'hB3);
        wr(A_STAT, 8'h00); rd(A_STAT, v); chk(!v[4], "R13 arb lost cleared", v[4], 0);
        // R9 repeated START
        s0 = starts; p0 = stops;
        wr(A_CTRL, 8'hF4); idle(40);
        chk(starts == s0 + 1 && stops == p0, "R9 restart", starts - s0, 1);
        rd(A_STAT, v); chk(v[5], "R9 busy kept", v[5], 1);
        rd(A_CTRL, v); chk(v == 8'hF0, "R2 restart bit reads 0", v, 8'hF0);
        // R6 receive
        wr(A_CTRL, 8'hE0);
        pat = {8'hC3, 1'b1}; idx = 0;
        rd(A_DATA, v); wait_irq("R6 rx byte 0");
        chk(cap[0] == 1'b0, "R6 master ack", cap[0], 0);
        wr(A_STAT, 8'h00);
        pat = {8'h5E, 1'b1}; idx = 0;
        rd(A_DATA, v); chk(v == 8'hC3, "R6 rx byte 0 value", v, 8'hC3);
        idle(30); wr(A_CTRL, 8'hE8);
        wait_irq("R6 rx byte 1");
        chk(cap[0] == 1'b0, "R6 ack captured at byte start", cap[0], 0);
        wr(A_STAT, 8'h00);
        pat = {8'h96, 1'b1}; idx = 0;
        rd(A_DATA, v); chk(v == 8'h5E, "R6 rx byte 1 value", v, 8'h5E);
        wait_irq("R6 rx byte 2");
        chk(cap[0] == 1'b1, "R6 master nack", cap[0], 1);
        wr(A_STAT, 8'h00);
        // R7 STOP, R8 no extra clock
        p0 = stops;
        wr(A_CTRL, 8'hC8); idle(40);
        chk(stops == p0 + 1, "R7 stop seen", stops - p0, 1);
        rd(A_STAT, v); chk(!v[5], "R7 busy cleared", v[5], 0);
        chk(scl_out && sda_out, "R7 lines released", {scl_out, sda_out}, 3);
        r0 = rises;
        rd(A_DATA, v); chk(v == 8'h96, "R8 final byte", v, 8'h96);
        idle(60); chk(rises == r0, "R8 no extra clock", rises - r0, 0);
        // R11 other divider code
        wr(A_DIV, 8'h09); wr(A_CTRL, 8'hF0); idle(40);
        pat = 9'h1FE; idx = 0;
        wr(A_DATA, 8'h55); wait_irq("R11 byte done");
        chk(hi_len == 18, "R11 high time code 9", hi_len, 18);
        chk(cap[8:1] == 8'h55, "R4 byte at code 9", cap[8:1], 8'h55);
        wr(A_STAT, 8'h00);
        // R12 abort mid-byte
        idx = 0; wr(A_DATA, 8'hAA); idle(60);
        wr(A_CTRL, 8'h00); idle(2);
        chk(scl_out && sda_out, "R12 lines released", {scl_out, sda_out}, 3);
        rd(A_STAT, v); chk(!v[5] && v[7], "R12 idle status", v, 8'h80);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule